// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Group

This block holds the interrupt, status and configuration registers of a flash controller. A simple register bus with a one-cycle write strobe and a combinational read port reaches them. An operation engine, which is outside this block, reports each finished operation as a one-cycle event that carries a kind code and an error flag. The block records a per-kind done bit and a master pending bit in the interrupt status register. It records error bits in the controller status register.

Software acknowledges completions by writing an AND mask to the interrupt status register. When the master pending bit ends up clear, all error bits are wiped in the same write. While the master bit is set, new command writes are refused. An accepted command is passed to the engine as a one-cycle strobe with its code. The interrupt pin polarity comes from a configuration bit. A ready output copies another configuration bit each time the configuration register is written. Cold reset, which is asynchronous and active low, and warm reset, which is synchronous, load different interrupt status values.

Top module: `flash_irq_regs`

## Requirements
- R1: After cold reset: controller status reads 0x0000, interrupt status reads 0x8080, configuration reads 0x40C0, second configuration reads 0x0000, command reads 0x0000, and rdy is 1.
- R2: A one-cycle warm_rst loads the same values as R1, except that interrupt status loads 0x8010.
- R3: A write to interrupt status (address 1) stores the old value ANDed with the written data.
- R4: When bit 15 of interrupt status is 0 after such a write, status error bits 13..10 are cleared. When bit 15 stays 1, they are kept.
- R5: An event with evt_kind k sets interrupt bit 15 and done bit 4+k. The kind codes are 0 reset, 1 erase, 2 program and 3 load.
- R6: An event with evt_err=1 sets command-error bit 10 and error bit 10+k in the controller status register (address 0).
- R7: irq equals interrupt bit 15 XOR NOT configuration bit 6. When bit 6 is 1 the pin is active high.
- R8: A write to the configuration register (address 2) sets rdy to bit 7 of the written data on the next cycle.
- R9: A command write (address 4) is discarded while interrupt bit 15 is 1. Otherwise the code is stored and cmd_strobe pulses for one cycle with cmd_code equal to it.
- R10: A configuration read returns the stored value with bits 4..0 zero.
- R11: The second configuration register (address 3) reads back exactly what was written.
- R12: When an event and an interrupt status write fall in the same cycle, the mask is applied first and the event's bits are set after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 status, 1 interrupt, 2 config, 3 config 2, 4 command) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| evt_valid | input | 1 | Completion event strobe |
| evt_kind | input | 2 | Completion kind |
| evt_err | input | 1 | Completion carried an error |
| irq | output | 1 | Interrupt pin |
| rdy | output | 1 | Ready pin |
| cmd_strobe | output | 1 | Accepted command pulse |
| cmd_code | output | 16 | Last accepted command |

## Verification
A wrong interrupt status bit shows at the irq pin in the same cycle, because the pin is formed from the register combinationally. It also shows as a refused or wrongly accepted command one cycle after the next command write. Lost or stale error bits show on the very next status read after an acknowledge write. The mask sweep, the event-kind sweep and the configuration sweep each read the registers back one cycle after every write, so a fault appears on the vector that causes it.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
    localparam int DW = 16;

    localparam int INT_RST = 4;
    localparam int INT_MST = 15;
    localparam int ERR_CMD = 10;
    localparam int CFG_POL = 6;
    localparam int CFG_RDY = 7;
    localparam int CFG_RSV = 5;

    localparam logic [DW-1:0] CFG_RST  = 16'h40C0;
    localparam logic [DW-1:0] INT_COLD = 16'h8080;
    localparam logic [DW-1:0] INT_WARM = 16'h8010;

    typedef enum logic [1:0] {
        EV_RESET = 2'd0,
        EV_ERASE = 2'd1,
        EV_PROG  = 2'd2,
        EV_LOAD  = 2'd3
    } ev_kind_e;

    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_INT    = 3'd1,
        RA_CFG    = 3'd2,
        RA_CFG2   = 3'd3,
        RA_CMD    = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [DW-1:0] intr;
        logic [DW-1:0] stat;
    } ev_state_t;

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] cfg2;
        logic          rdy;
    } cfg_state_t;

    typedef struct packed {
        logic [DW-1:0] cmd;
        logic          strobe;
    } cmd_state_t;
endpackage

// File: rtl/fir_event_regs.sv
module fir_event_regs
    import flash_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          int_wr,
    input  logic [DW-1:0] wdata,
    input  logic          evt_valid,
    input  logic [1:0]    evt_kind,
    input  logic          evt_err,
    output logic [DW-1:0] int_q,
    output logic [DW-1:0] stat_q
);
    localparam int NERR = 4;

    ev_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (int_wr) begin
            r_d.intr = r_q.intr & wdata;
            if (!r_d.intr[INT_MST]) begin
                r_d.stat[ERR_CMD +: NERR] = '0;
            end
        end
        if (evt_valid) begin
            r_d.intr[INT_MST] = 1'b1;
            r_d.intr[INT_RST + int'(evt_kind)] = 1'b1;
            if (evt_err) begin
                r_d.stat[ERR_CMD] = 1'b1;
                r_d.stat[ERR_CMD + int'(evt_kind)] = 1'b1;
            end
        end
        if (warm_rst) begin
            r_d.intr = INT_WARM;
            r_d.stat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.intr <= INT_COLD;
            r_q.stat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign int_q  = r_q.intr;
    assign stat_q = r_q.stat;

    assert_and_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr && !evt_valid && !warm_rst |=> (int_q & ~$past(wdata)) == '0);

    assert_err_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr && !wdata[INT_MST] && !evt_valid && !warm_rst |=> stat_q[ERR_CMD +: NERR] == '0);

    assert_evt_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !warm_rst |=> int_q[INT_MST]);

    assert_err_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_err && !warm_rst |=> stat_q[ERR_CMD]);
endmodule

// File: rtl/fir_cfg_regs.sv
module fir_cfg_regs
    import flash_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          cfg_wr,
    input  logic          cfg2_wr,
    input  logic [DW-1:0] wdata,
    input  logic          int_master,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] cfg2_q,
    output logic          rdy,
    output logic          irq
);
    cfg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_wr) begin
            r_d.cfg = wdata;
            r_d.rdy = wdata[CFG_RDY];
        end
        if (cfg2_wr) begin
            r_d.cfg2 = wdata;
        end
        if (warm_rst) begin
            r_d.cfg  = CFG_RST;
            r_d.cfg2 = '0;
            r_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg  <= CFG_RST;
            r_q.cfg2 <= '0;
            r_q.rdy  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_q  = r_q.cfg;
    assign cfg2_q = r_q.cfg2;
    assign rdy    = r_q.rdy;
    assign irq    = int_master ^ ~r_q.cfg[CFG_POL];

    assert_rdy_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !warm_rst |=> rdy == $past(wdata[CFG_RDY]));
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
    import flash_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          evt_valid,
    input  logic [1:0]    evt_kind,
    input  logic          evt_err,
    output logic          irq,
    output logic          rdy,
    output logic          cmd_strobe,
    output logic [15:0]   cmd_code
);
    logic [DW-1:0] int_q, stat_q, cfg_q, cfg2_q;
    logic          wr_int, wr_cfg, wr_cfg2, wr_cmd;

    assign wr_int  = bus_wr && (bus_addr == RA_INT);
    assign wr_cfg  = bus_wr && (bus_addr == RA_CFG);
    assign wr_cfg2 = bus_wr && (bus_addr == RA_CFG2);
    assign wr_cmd  = bus_wr && (bus_addr == RA_CMD);

    fir_event_regs u_ev (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst  (warm_rst),
        .int_wr    (wr_int),
        .wdata     (bus_wdata),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_err   (evt_err),
        .int_q     (int_q),
        .stat_q    (stat_q)
    );

    fir_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_rst   (warm_rst),
        .cfg_wr     (wr_cfg),
        .cfg2_wr    (wr_cfg2),
        .wdata      (bus_wdata),
        .int_master (int_q[INT_MST]),
        .cfg_q      (cfg_q),
        .cfg2_q     (cfg2_q),
        .rdy        (rdy),
        .irq        (irq)
    );

    cmd_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        c_d.strobe = 1'b0;
        if (wr_cmd && !int_q[INT_MST]) begin
            c_d.cmd    = bus_wdata;
            c_d.strobe = 1'b1;
        end
        if (warm_rst) begin
            c_d.cmd    = '0;
            c_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cmd    <= '0;
            c_q.strobe <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cmd_strobe = c_q.strobe;
    assign cmd_code   = c_q.cmd;

    always_comb begin
        case (bus_addr)
            RA_STATUS: bus_rdata = stat_q;
            RA_INT:    bus_rdata = int_q;
            RA_CFG:    bus_rdata = {cfg_q[DW-1:CFG_RSV], {CFG_RSV{1'b0}}};
            RA_CFG2:   bus_rdata = cfg2_q;
            RA_CMD:    bus_rdata = c_q.cmd;
            default:   bus_rdata = '0;
        endcase
    end

    assert_cmd_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && int_q[INT_MST] && !warm_rst |=> !cmd_strobe && $stable(cmd_code));

    assert_irq_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_POL] && int_q[INT_MST] |-> irq);

    assert_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_POL] && !int_q[INT_MST] |-> !irq);
endmodule

// File: tb/sim_flash_irq_regs.sv
module sim_flash_irq_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic        evt_err = 1'b0;
    logic        irq, rdy, cmd_strobe;
    logic [15:0] cmd_code;

    int nvec = 0;
    int nbad = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_err(evt_err), .irq(irq), .rdy(rdy),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ev(input logic [1:0] k, input logic e);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_err = e;
        @(negedge clk);
        evt_valid = 1'b0; evt_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [15:0] v, exp_i, exp_s;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd("R1 status", 3'd0, 16'h0000);
        rd("R1 int", 3'd1, 16'h8080);
        rd("R1 cfg", 3'd2, 16'h40C0);
        rd("R1 cfg2", 3'd3, 16'h0000);
        rd("R1 cmd", 3'd4, 16'h0000);
        check("R1 rdy", {15'd0, rdy}, 16'd1);
        check("R7 irq at reset", {15'd0, irq}, 16'd1);

        wr(3'd4, 16'h0055);
        check("R9 refused strobe", {15'd0, cmd_strobe}, 16'd0);
        rd("R9 refused code", 3'd4, 16'h0000);

        wr(3'd1, 16'h0000);
        rd("R3 clear all", 3'd1, 16'h0000);
        check("R7 irq idle", {15'd0, irq}, 16'd0);

        wr(3'd4, 16'h00A5);
        check("R9 strobe", {15'd0, cmd_strobe}, 16'd1);
        check("R9 code", cmd_code, 16'h00A5);
        @(negedge clk);
        check("R9 strobe one cycle", {15'd0, cmd_strobe}, 16'd0);

        for (int k = 0; k < 4; k++) begin
            for (int e = 0; e < 2; e++) begin
                wr(3'd1, 16'h0000);
                ev(2'(k), 1'(e));
                rd("R5 done bits", 3'd1, 16'h8000 | (16'h1 << (4 + k)));
                exp_s = (e != 0) ? ((16'h1 << 10) | (16'h1 << (10 + k))) : 16'h0;
                rd("R6 error bits", 3'd0, exp_s);
                wr(3'd1, 16'hFFFF);
                rd("R4 errors kept", 3'd0, exp_s);
                wr(3'd1, 16'h7FFF);
                rd("R4 errors wiped", 3'd0, 16'h0000);
            end
        end

        for (int i = 0; i < 64; i++) begin
            v = 16'(i) * 16'h0C31 ^ 16'hA5A5;
            wr(3'd1, 16'h0000);
            ev(2'd0, 1'b0); ev(2'd1, 1'b0); ev(2'd2, 1'b0); ev(2'd3, 1'b1);
            wr(3'd1, v);
            exp_i = 16'h80F0 & v;
            rd("R3 mask", 3'd1, exp_i);
            exp_s = exp_i[15] ? 16'h2400 : 16'h0000;
            rd("R4 mask errors", 3'd0, exp_s);
        end

        wr(3'd1, 16'h0000);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0000;
        evt_valid = 1'b1; evt_kind = 2'd1; evt_err = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_valid = 1'b0; evt_err = 1'b0;
        rd("R12 int", 3'd1, 16'h8020);
        rd("R12 status", 3'd0, 16'h0C00);

        wr(3'd1, 16'h0000);
        for (int i = 0; i < 256; i++) begin
            v = 16'(i) * 16'h0101 ^ 16'h3C5A;
            wr(3'd2, v);
            rd("R10 cfg read", 3'd2, v & 16'hFFE0);
            check("R8 rdy", {15'd0, rdy}, {15'd0, v[7]});
            check("R7 irq master clear", {15'd0, irq}, {15'd0, ~v[6]});
            wr(3'd3, v);
            rd("R11 cfg2", 3'd3, v);
        end
        ev(2'd2, 1'b0);
        for (int i = 0; i < 4; i++) begin
            v = 16'(i) << 6;
            wr(3'd2, v);
            check("R7 irq master set", {15'd0, irq}, {15'd0, v[6]});
            check("R8 rdy", {15'd0, rdy}, {15'd0, v[7]});
        end

        wr(3'd1, 16'h0000);
        wr(3'd4, 16'h1234);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'hBEEF);
        ev(2'd3, 1'b1);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        rd("R2 int", 3'd1, 16'h8010);
        rd("R2 status", 3'd0, 16'h0000);
        rd("R2 cfg", 3'd2, 16'h40C0);
        rd("R2 cfg2", 3'd3, 16'h0000);
        rd("R2 cmd", 3'd4, 16'h0000);
        check("R2 rdy", {15'd0, rdy}, 16'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule